// File: doc/BRIEF.md
# Enable-Framed Static RAM Cell Array

This block is a synthesizable behavioural model of a 4096 x 1 static RAM. Each access is framed by an active-low chip enable. When the enable falls, the block captures the address, the write-enable level and the input bit. The captured write-enable level fixes the kind of cycle for as long as the enable stays low:

- **Read.** The write enable was high when the enable fell. The output drive flag rises, and the stored bit is presented after a fixed number of clock cycles. While the bit is on the output, a data-valid flag marks it.
- **Early write.** The write enable was low when the enable fell. The output never drives. The captured bit is written into the cell when the enable returns high.
- **Read-modify-write.** This starts as a read. A falling write enable during the read captures the input bit and writes it into the cell. The output keeps the value that was read until the enable rises.

All inputs are sampled on one system clock. Edge detection on the enable and the write enable replaces real latches. The output drive flag stands in for a three-state buffer. The pins are plain control and data pins, sampled every clock, with no handshake. The cell array is a 64 x 64 matrix. The upper six address bits pick the row and the lower six bits pick the column.

Top module: `encl_sram`

## Requirements
- R1: After reset `dout_oe`, `dout_valid` and `dout` are all 0.
- R2: The address and input bit are captured in the clock in which `ce_n` is first seen low. Changes to `addr` or `din` later in the same enable-low period do not alter the bit that is read or written.
- R3: If `we_n` is low in the clock where `ce_n` is first seen low, the cycle is an early write, and `dout_oe` stays 0 until `ce_n` returns high. Toggling `we_n` later in that period neither drives the output nor starts a new capture.
- R4: An early write stores the captured bit in the clock where `ce_n` is first seen high again. A read started in the very next clock returns the new bit.
- R5: If `we_n` is high in the clock where `ce_n` is first seen low, `dout_oe` is 1 from the following clock until the enable rises.
- R6: During a read, `dout_valid` rises exactly N_ACCESS clocks after the capture clock. Until it rises, `dout` is 0. While it is high, `dout` holds the stored bit and does not change.
- R7: A falling `we_n` during a read turns the cycle into read-modify-write. The live `din` is captured and written into the cell at that clock. `dout` and `dout_valid` keep their values until `ce_n` rises. Later changes to `we_n` or `din` have no effect.
- R8: In the clock after `ce_n` is seen high again, `dout_oe`, `dout_valid` and `dout` are all 0.
- R9: `addr[11:6]` selects the row and `addr[5:0]` selects the column. Two addresses that differ only in row, or only in column, are independent cells.
- R10: While `ce_n` is high, activity on `we_n`, `din` and `addr` changes no stored bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Active-low chip enable that frames each cycle |
| we_n | input | 1 | Active-low write enable |
| addr | input | 12 | Cell address: row in the upper six bits, column in the lower six |
| din | input | 1 | Input data bit |
| dout | output | 1 | Output data bit; 0 unless `dout_valid` is high |
| dout_oe | output | 1 | Output drive flag, standing in for a three-state buffer |
| dout_valid | output | 1 | High while `dout` carries valid read data |

## Verification
The assertions take three things for granted about the inputs:

- `ce_n` stays high for at least one clock between cycles, so each capture clock is preceded by a clock with the enable high.
- The input pins are synchronous to `clk`.
- In a read-modify-write, `we_n` stays high until `dout_valid` has risen.

The stimulus keeps within these limits. Every task releases the enable and holds it high for at least one clock before the next cycle. Inputs are changed only on falling clock edges. The write enable is lowered only after the bench has seen valid data. Cells are read only after they have been written, so no uninitialised value reaches the output.

// File: rtl/encl_sram_pkg.sv
package encl_sram_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE = 2'd0,
    CYC_READ = 2'd1,
    CYC_EWR  = 2'd2,
    CYC_RMW  = 2'd3
  } cyc_e;
endpackage

// File: rtl/encl_edge_det.sv
// Single-edge detector on a clock-sampled level; history resets high (idle).
module encl_edge_det #(
  parameter bit RISING = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic pulse
);
  logic sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= 1'b1;
    else        sig_q <= sig;
  end

  generate
    if (RISING) begin : g_rise
      assign pulse = ~sig_q & sig;
    end else begin : g_fall
      assign pulse = sig_q & ~sig;
    end
  endgenerate
endmodule

// File: rtl/encl_sram_cells.sv
// Row x column bit matrix with one write port and a registered, enabled read.
module encl_sram_cells #(
  parameter int ROW_BITS = 6,
  parameter int COL_BITS = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ROW_BITS-1:0] row,
  input  logic [COL_BITS-1:0] col,
  input  logic                wr_bit,
  input  logic                rd_en,
  output logic                rd_bit
);
  localparam int AW    = ROW_BITS + COL_BITS;
  localparam int DEPTH = 1 << AW;

  logic          cells [DEPTH];
  logic [AW-1:0] cell_idx;

  assign cell_idx = {row, col};

  always_ff @(posedge clk) begin
    if (wr_en) cells[cell_idx] <= wr_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_bit <= 1'b0;
    else if (rd_en) rd_bit <= cells[cell_idx];
  end
endmodule

// File: rtl/encl_sram_ctrl.sv
// Cycle sequencer: captures on the enable fall, converts to read-modify-write
// on a write-enable fall during a read, and releases on the enable rise.
module encl_sram_ctrl
  import encl_sram_pkg::*;
#(
  parameter int AW       = 12,
  parameter int N_ACCESS = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_fall,
  input  logic          ce_rise,
  input  logic          we_fall,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic          din,
  output cyc_e          cyc,
  output logic [AW-1:0] addr_lat,
  output logic          wr_en,
  output logic          wr_bit,
  output logic          rd_en,
  output logic          drive,
  output logic          data_ok
);
  localparam int CW = (N_ACCESS < 1) ? 1 : $clog2(N_ACCESS + 1);
  localparam logic [CW-1:0] ACC_LAST = CW'(N_ACCESS);

  logic          din_lat;
  logic [CW-1:0] acc_cnt;
  logic          rmw_go;

  // A write-enable fall only converts a read that is still in progress.
  assign rmw_go = (cyc == CYC_READ) && we_fall && !ce_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc      <= CYC_IDLE;
      addr_lat <= '0;
      din_lat  <= 1'b0;
      acc_cnt  <= '0;
    end else if (ce_fall) begin
      cyc      <= we_n ? CYC_READ : CYC_EWR;
      addr_lat <= addr;
      din_lat  <= din;
      acc_cnt  <= '0;
    end else if (ce_rise) begin
      cyc     <= CYC_IDLE;
      acc_cnt <= '0;
    end else begin
      if (rmw_go) begin
        cyc     <= CYC_RMW;
        din_lat <= din;
      end
      if (drive && acc_cnt != ACC_LAST) acc_cnt <= acc_cnt + 1'b1;
    end
  end

  always_comb begin
    drive   = (cyc == CYC_READ) || (cyc == CYC_RMW);
    data_ok = drive && (acc_cnt == ACC_LAST);
    rd_en   = (cyc == CYC_READ);
    wr_en   = (ce_rise && cyc == CYC_EWR) || rmw_go;
    wr_bit  = rmw_go ? din : din_lat;
  end
endmodule

// File: rtl/encl_sram.sv
module encl_sram
  import encl_sram_pkg::*;
#(
  parameter int ROW_BITS = 6,
  parameter int COL_BITS = 6,
  parameter int N_ACCESS = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ce_n,
  input  logic                     we_n,
  input  logic [ROW_BITS+COL_BITS-1:0] addr,
  input  logic                     din,
  output logic                     dout,
  output logic                     dout_oe,
  output logic                     dout_valid
);
  localparam int AW = ROW_BITS + COL_BITS;

  logic          ce_fall, ce_rise, we_fall;
  cyc_e          cyc;
  logic [AW-1:0] addr_lat;
  logic          wr_en, wr_bit, rd_en, rd_bit, drive, data_ok;

  encl_edge_det #(.RISING(1'b0)) u_ce_fall (
    .clk(clk), .rst_n(rst_n), .sig(ce_n), .pulse(ce_fall));
  encl_edge_det #(.RISING(1'b1)) u_ce_rise (
    .clk(clk), .rst_n(rst_n), .sig(ce_n), .pulse(ce_rise));
  encl_edge_det #(.RISING(1'b0)) u_we_fall (
    .clk(clk), .rst_n(rst_n), .sig(we_n), .pulse(we_fall));

  encl_sram_ctrl #(.AW(AW), .N_ACCESS(N_ACCESS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_fall(ce_fall), .ce_rise(ce_rise),
    .we_fall(we_fall), .we_n(we_n), .addr(addr), .din(din), .cyc(cyc),
    .addr_lat(addr_lat), .wr_en(wr_en), .wr_bit(wr_bit), .rd_en(rd_en),
    .drive(drive), .data_ok(data_ok));

  encl_sram_cells #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_cells (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .row(addr_lat[AW-1:COL_BITS]), .col(addr_lat[COL_BITS-1:0]),
    .wr_bit(wr_bit), .rd_en(rd_en), .rd_bit(rd_bit));

  assign dout_oe    = drive;
  assign dout_valid = data_ok;
  assign dout       = data_ok & rd_bit;
endmodule

// File: rtl/encl_sram_chk.sv
module encl_sram_chk
  import encl_sram_pkg::*;
#(
  parameter int N_ACCESS = 3
) (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic we_n,
  input logic dout,
  input logic dout_oe,
  input logic dout_valid,
  input cyc_e cyc
);
  localparam int SW = $clog2(N_ACCESS + 2) + 1;
  localparam logic [SW-1:0] SAT = SW'(N_ACCESS + 1);

  logic          ce_seen;
  logic [SW-1:0] since_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_seen    <= 1'b1;
      since_fall <= SAT;
    end else begin
      ce_seen <= ce_n;
      if (ce_seen && !ce_n)     since_fall <= '0;
      else if (since_fall != SAT) since_fall <= since_fall + 1'b1;
    end
  end

  // R3
  ewr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_seen && !ce_n && !we_n) |=> !dout_oe);
  // R5
  rd_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_seen && !ce_n && we_n) |=> dout_oe);
  // R6
  valid_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_valid) |-> (since_fall == SW'(N_ACCESS)));
  // R6
  valid_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> dout_oe);
  // R7
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && $past(dout_valid)) |-> $stable(dout));
  // R7
  rmw_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CYC_RMW) |=> (ce_seen || cyc == CYC_RMW));
  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ce_n) |-> (!dout_oe && !dout_valid && !dout));
endmodule

bind encl_sram encl_sram_chk #(.N_ACCESS(N_ACCESS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .dout(dout),
  .dout_oe(dout_oe), .dout_valid(dout_valid), .cyc(cyc));

// File: tb/encl_sram_bench.sv
`timescale 1ns/1ps
module encl_sram_bench;
  localparam int NACC = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, we_n = 1'b1, din = 1'b0;
  logic [11:0] addr = '0;
  logic        dout, dout_oe, dout_valid;
  int          n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  encl_sram #(.ROW_BITS(6), .COL_BITS(6), .N_ACCESS(NACC)) u_encl_sram (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr),
    .din(din), .dout(dout), .dout_oe(dout_oe), .dout_valid(dout_valid));

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_idle(input string req);
    check({req, " oe"}, {31'd0, dout_oe}, 0);
    check({req, " valid"}, {31'd0, dout_valid}, 0);
    check({req, " dout"}, {31'd0, dout}, 0);
  endtask

  // Early write; scrambles inputs after capture (R2, R3).
  task automatic do_ewrite(input logic [11:0] a, input logic d);
    ce_n = 1'b0; we_n = 1'b0; addr = a; din = d;
    @(negedge clk);
    check("R3 ewr oe", {31'd0, dout_oe}, 0);
    addr = a ^ 12'h041; din = ~d; we_n = 1'b1;
    @(negedge clk);
    check("R3 ewr oe after we toggle", {31'd0, dout_oe}, 0);
    we_n = 1'b0;
    @(negedge clk);
    check("R3 ewr oe after we refall", {31'd0, dout_oe}, 0);
    ce_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
    expect_idle("R8 ewr release");
  endtask

  // Read with optional address disturbance after capture.
  task automatic do_read(input logic [11:0] a, input logic exp,
                         input bit disturb);
    ce_n = 1'b0; we_n = 1'b1; addr = a;
    @(negedge clk);
    check("R5 rd oe", {31'd0, dout_oe}, 1);
    check("R6 rd not yet valid", {31'd0, dout_valid}, 0);
    if (disturb) begin addr = a ^ 12'h041; din = ~din; end
    for (int j = 1; j <= NACC; j++) begin
      @(negedge clk);
      if (j < NACC) begin
        check("R6 rd early valid", {31'd0, dout_valid}, 0);
        check("R6 rd early dout", {31'd0, dout}, 0);
      end
    end
    check("R6 rd valid", {31'd0, dout_valid}, 1);
    check("R2 R9 rd data", {31'd0, dout}, {31'd0, exp});
    @(negedge clk);
    check("R6 rd data held", {31'd0, dout}, {31'd0, exp});
    ce_n = 1'b1;
    @(negedge clk);
    expect_idle("R8 rd release");
  endtask

  // Read-modify-write: old value stays on output, new stored.
  task automatic do_rmw(input logic [11:0] a, input logic old_b,
                        input logic new_b);
    ce_n = 1'b0; we_n = 1'b1; addr = a;
    repeat (NACC + 1) @(negedge clk);
    check("R6 rmw read valid", {31'd0, dout_valid}, 1);
    check("R7 rmw read old", {31'd0, dout}, {31'd0, old_b});
    we_n = 1'b0; din = new_b;
    @(negedge clk);
    check("R7 rmw dout keeps old", {31'd0, dout}, {31'd0, old_b});
    check("R7 rmw valid kept", {31'd0, dout_valid}, 1);
    din = ~new_b; we_n = 1'b1;
    @(negedge clk);
    we_n = 1'b0;
    @(negedge clk);
    check("R7 rmw dout after we toggle", {31'd0, dout}, {31'd0, old_b});
    ce_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
    expect_idle("R8 rmw release");
    do_read(a, new_b, 1'b0);
  endtask

  // Activity with enable high must not write (R10).
  task automatic idle_noise(input logic [11:0] a);
    for (int k = 0; k < 4; k++) begin
      addr = a; din = k[0]; we_n = k[1];
      @(negedge clk);
      check("R10 idle oe", {31'd0, dout_oe}, 0);
    end
    we_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog all-reqs actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_idle("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    expect_idle("R1 after reset");

    do_ewrite(12'h000, 1'b1);
    do_ewrite(12'h040, 1'b0);   // row differs (R9)
    do_ewrite(12'h001, 1'b0);   // column differs (R9)
    do_ewrite(12'hFFF, 1'b1);
    do_ewrite(12'h041, 1'b1);

    do_read(12'h000, 1'b1, 1'b1);  // R2 address scrambled to 041
    do_read(12'h040, 1'b0, 1'b1);
    do_read(12'h001, 1'b0, 1'b0);
    do_read(12'hFFF, 1'b1, 1'b0);
    do_read(12'h041, 1'b1, 1'b0);

    idle_noise(12'h000);
    do_read(12'h000, 1'b1, 1'b0);  // R10

    do_ewrite(12'h7A5, 1'b1);       // R4 back-to-back
    do_read(12'h7A5, 1'b1, 1'b0);
    do_ewrite(12'h7A5, 1'b0);
    do_read(12'h7A5, 1'b0, 1'b0);

    do_rmw(12'hFFF, 1'b1, 1'b0);    // R7
    do_rmw(12'h040, 1'b0, 1'b1);
    do_read(12'h000, 1'b1, 1'b0);   // R9 neighbour untouched

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule